// File: doc/BRIEF.md
# Contactless Tag Session Controller

This block is the protocol core of a tag emulator. It sits between a bit-level receiver, which delivers whole descrambled frames with their bit counts, and a transmitter, which serialises reply frames and applies the keystream. It owns a byte-wide storage array and a 4-bit checksum unit. It also steers an external keystream generator by loading its seed.

A session starts from idle when a carrier is seen. The controller clears the keystream seed and waits for a 7-bit initialisation vector, which becomes the new seed. It answers with a 6-bit code that identifies the configured card size, then checks the reader's 6-bit acknowledge. After that it serves reads and writes until a frame is malformed, a checksum fails or the receiver reports an error. Any of these sends it back to idle.

The card size is a static configuration input. It fixes the command width and the address width. Reads and writes carry no opcode that tells them apart. They are classified by frame length alone.

Top module: `tag_session_ctrl`

## Requirements
- R1: After reset, `tx_req`, `tx_ack`, `ks_load` and `gap_extend` are low.
- R2: In idle with a valid `card_type` (0, 1 or 2), a high `carrier` at a clock edge produces a one-cycle `ks_load` with `ks_seed` = 0 after that edge. With `card_type` = 3 the controller stays idle: it never raises `ks_load` or `tx_req`.
- R3: While waiting for the initialisation vector, a 7-bit frame raises `ks_load` with `ks_seed` = `rx_data[6:0]` after the capturing edge. In the same cycle it raises `tx_req` with `tx_len` = 6, `tx_ack` = 0 and `tx_data` = 0x0D (type 0), 0x1D (type 1) or 0x3D (type 2). A frame of any other length returns the controller to idle without a reply.
- R4: The acknowledge must be a 6-bit frame whose value is 0x19 for type 0, or 0x39 for types 1 and 2. On a match, `gap_extend` pulses for one cycle after the capturing edge and the session opens. Any other frame or `rx_err` returns the controller to idle.
- R5: In an open session, a frame whose length equals the command width (6, 8+1 = 9, or 11 bits for types 0, 1, 2) is a read. Bit 0 is the direction flag. The address is the frame shifted right by one, masked to 5, 8 or 10 bits. Two edges after capture, `tx_req` rises with `tx_len` = 12, `tx_ack` = 0, the stored byte in `tx_data[7:0]` and the checksum in `tx_data[11:8]`.
- R6: A frame whose length is the command width plus 12 is a write. Bit 0 is the flag, the address sits in bits 1 upward, the data byte starts at bit position equal to the command width, and the 4-bit checksum sits directly above the byte. If the checksum matches, the byte is stored and `tx_req` rises one edge later with `tx_ack` = 1, `tx_len` = 1 and `tx_data` = 1.
- R7: A write with a wrong checksum leaves the storage unchanged, sends no reply and ends the session.
- R8: The checksum is 4 bits wide and starts from 0x5. It is computed over cmd_width + 8 bits of (byte << cmd_width) | cmd, least significant bit first. Each step is: feedback = state[0] xor bit, shift the state right, and xor in 0xC when feedback is 1. For a write, cmd is the address shifted left by one with bit 0 clear.
- R9: In an open session, a frame of any other length, or a pulse on `rx_err`, ends the session without a reply.
- R10: `tx_req` and its `tx_len`/`tx_data`/`tx_ack` stay constant until `tx_done`. `tx_req` is low after the edge that samples `tx_done`; a reply in an open session then returns to command wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_type | input | 2 | Card size selection: 0, 1, 2; 3 is invalid |
| carrier | input | 1 | Reader field present |
| rx_valid | input | 1 | One-cycle strobe: a complete frame is on rx_len/rx_data |
| rx_err | input | 1 | One-cycle strobe: receive code violation or timeout |
| rx_len | input | 5 | Received frame length in bits |
| rx_data | input | 23 | Descrambled frame, first bit received in bit 0, unused bits zero |
| tx_req | output | 1 | Reply frame pending, held until tx_done |
| tx_len | output | 4 | Reply length in bits |
| tx_data | output | 12 | Reply bits, first transmitted in bit 0 |
| tx_ack | output | 1 | Reply is the unscrambled write acknowledge slot |
| tx_done | input | 1 | One-cycle strobe from the transmitter: reply finished |
| ks_load | output | 1 | One-cycle strobe: load ks_seed into the keystream generator |
| ks_seed | output | 7 | Keystream seed value |
| gap_extend | output | 1 | One-cycle strobe: push the frame timestamp one bit period later |

## Verification
Every result has a fixed latency counted from the edge that samples the stimulus. The seed load, the type reply, the acknowledge pulse and the write acknowledge appear one edge later. A read reply appears two edges later, because the storage read is registered, so the bench also confirms that `tx_req` is still low after the first edge. Stimuli are driven on the falling edge and outputs are sampled on the next falling edge, one or two at a time, so each check lands exactly on its due cycle. After `tx_done`, `tx_req` is checked one edge later. A session that should have ended is probed by issuing a valid read and confirming that no reply follows.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int FRAME_MAX  = 23;   // longest reader frame
   localparam int CMD_MAX    = 11;   // widest command
   localparam int ADDR_MAX   = 10;   // widest address
   localparam int IV_BITS    = 7;
   localparam int CODE_BITS  = 6;
   localparam int REPLY_BITS = 12;
   localparam int CRC_BITS   = 4;
   localparam int CRC_SPAN   = CMD_MAX + 8;   // longest checksum input
   localparam int LEN_W      = $clog2(FRAME_MAX + 1);

   typedef enum logic [2:0] {
      S_IDLE,
      S_IV,
      S_TYPE,
      S_ACK,
      S_CMD,
      S_READ,
      S_REPLY
   } tsc_state_t;
endpackage

// File: rtl/tsc_card_decode.sv
module tsc_card_decode
   import tsc_pkg::*;
(
   input  logic [1:0]            card_type,
   output logic                  type_ok,
   output logic [3:0]            cmd_w,
   output logic [ADDR_MAX-1:0]   addr_mask,
   output logic [CODE_BITS-1:0]  type_code,
   output logic [CODE_BITS-1:0]  ack_code
);
   always_comb begin
      type_ok   = 1'b1;
      cmd_w     = 4'd0;
      addr_mask = '0;
      type_code = '0;
      ack_code  = '0;
      unique case (card_type)
         2'd0: begin
            cmd_w     = 4'd6;
            addr_mask = 10'h01F;
            type_code = 6'h0D;
            ack_code  = 6'h19;
         end
         2'd1: begin
            cmd_w     = 4'd9;
            addr_mask = 10'h0FF;
            type_code = 6'h1D;
            ack_code  = 6'h39;
         end
         2'd2: begin
            cmd_w     = 4'd11;
            addr_mask = 10'h3FF;
            type_code = 6'h3D;
            ack_code  = 6'h39;
         end
         default: type_ok = 1'b0;
      endcase
   end
endmodule

// File: rtl/tsc_crc4.sv
module tsc_crc4 #(
   parameter int         W         = 4,
   parameter int         SPAN      = 19,
   parameter logic [W-1:0] POLY    = 4'hC,
   parameter logic [W-1:0] INIT    = 4'h5,
   parameter bit         LSB_FIRST = 1'b1,
   localparam int        NB_W      = $clog2(SPAN + 1)
) (
   input  logic [SPAN-1:0] payload,
   input  logic [NB_W-1:0] nbits,
   output logic [W-1:0]    crc
);
   generate
      if (W < 2) begin : g_bad_w
         $error("checksum width too small");
      end
      if (LSB_FIRST) begin : g_lsb
         logic [W-1:0] st;
         logic         fb;
         always_comb begin
            st = INIT;
            fb = 1'b0;
            for (int i = 0; i < SPAN; i++) begin
               if (i < int'(nbits)) begin
                  fb = st[0] ^ payload[i];
                  st = st >> 1;
                  if (fb) st = st ^ POLY;
               end
            end
            crc = st;
         end
      end else begin : g_msb
         logic [W-1:0] st;
         logic         fb;
         int           j;
         always_comb begin
            st = INIT;
            fb = 1'b0;
            j  = 0;
            for (int i = 0; i < SPAN; i++) begin
               if (i < int'(nbits)) begin
                  j  = int'(nbits) - 1 - i;
                  fb = st[W-1] ^ payload[j];
                  st = st << 1;
                  if (fb) st = st ^ POLY;
               end
            end
            crc = st;
         end
      end
   endgenerate
endmodule

// File: rtl/tsc_byte_ram.sv
module tsc_byte_ram #(
   parameter int AW    = 10,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
      if (re) rdata <= cells[raddr];
   end
endmodule

// File: rtl/tag_session_ctrl.sv
module tag_session_ctrl
   import tsc_pkg::*;
#(
   parameter int         MEM_AW        = 10,
   parameter bit         CRC_LSB_FIRST = 1'b1,
   parameter logic [3:0] CRC_POLY      = 4'hC,
   parameter logic [3:0] CRC_INIT      = 4'h5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  card_type,
   input  logic        carrier,
   input  logic        rx_valid,
   input  logic        rx_err,
   input  logic [4:0]  rx_len,
   input  logic [22:0] rx_data,
   output logic        tx_req,
   output logic [3:0]  tx_len,
   output logic [11:0] tx_data,
   output logic        tx_ack,
   input  logic        tx_done,
   output logic        ks_load,
   output logic [6:0]  ks_seed,
   output logic        gap_extend
);
   localparam int SPAN_W = $clog2(CRC_SPAN + 1);

   generate
      if (MEM_AW < ADDR_MAX) begin : g_bad_aw
         $error("storage too small for the largest card");
      end
   endgenerate

   tsc_state_t st;

   logic                  type_ok;
   logic [3:0]            cmd_w;
   logic [ADDR_MAX-1:0]   addr_mask;
   logic [CODE_BITS-1:0]  type_code;
   logic [CODE_BITS-1:0]  ack_code;

   tsc_card_decode u_dec (
      .card_type (card_type),
      .type_ok   (type_ok),
      .cmd_w     (cmd_w),
      .addr_mask (addr_mask),
      .type_code (type_code),
      .ack_code  (ack_code)
   );

   // frame lengths that select read and write
   logic [4:0] len_rd, len_wr;
   assign len_rd = {1'b0, cmd_w};
   assign len_wr = len_rd + 5'd12;

   // write field extraction from the live frame
   logic [ADDR_MAX-1:0] fr_addr;
   logic [7:0]          wr_byte;
   logic [3:0]          wr_crc_rx, wr_crc_calc;
   logic [CRC_SPAN-1:0] wr_payload;
   logic [SPAN_W-1:0]   span_bits;
   logic                crc_ok;

   assign fr_addr    = rx_data[ADDR_MAX:1] & addr_mask;
   assign wr_byte    = 8'(rx_data >> cmd_w);
   assign wr_crc_rx  = 4'(rx_data >> (len_rd + 5'd8));
   assign wr_payload = (CRC_SPAN'(wr_byte) << cmd_w) | CRC_SPAN'({fr_addr, 1'b0});
   assign span_bits  = SPAN_W'(len_rd + 5'd8);
   assign crc_ok     = (wr_crc_calc == wr_crc_rx);

   tsc_crc4 #(
      .W(CRC_BITS), .SPAN(CRC_SPAN), .POLY(CRC_POLY), .INIT(CRC_INIT),
      .LSB_FIRST(CRC_LSB_FIRST)
   ) u_crc_wr (
      .payload (wr_payload),
      .nbits   (span_bits),
      .crc     (wr_crc_calc)
   );

   // read path: registered storage read, checksum on the held command
   logic [CMD_MAX-1:0]  cmd_q;
   logic [CMD_MAX-1:0]  cmd_mask;
   logic [7:0]          mem_rdata;
   logic [CRC_SPAN-1:0] rd_payload;
   logic [3:0]          rd_crc;

   assign cmd_mask   = CMD_MAX'((12'd1 << cmd_w) - 12'd1);
   assign rd_payload = (CRC_SPAN'(mem_rdata) << cmd_w) | CRC_SPAN'(cmd_q & cmd_mask);

   tsc_crc4 #(
      .W(CRC_BITS), .SPAN(CRC_SPAN), .POLY(CRC_POLY), .INIT(CRC_INIT),
      .LSB_FIRST(CRC_LSB_FIRST)
   ) u_crc_rd (
      .payload (rd_payload),
      .nbits   (span_bits),
      .crc     (rd_crc)
   );

   logic in_cmd, wr_fire;
   assign in_cmd  = type_ok && (st == S_CMD) && rx_valid && !rx_err;
   assign wr_fire = in_cmd && (rx_len == len_wr) && crc_ok;

   tsc_byte_ram #(.AW(MEM_AW)) u_ram (
      .clk   (clk),
      .we    (wr_fire),
      .waddr (MEM_AW'(fr_addr)),
      .wdata (wr_byte),
      .re    (in_cmd),
      .raddr (MEM_AW'(fr_addr)),
      .rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         tx_req     <= 1'b0;
         tx_len     <= '0;
         tx_data    <= '0;
         tx_ack     <= 1'b0;
         ks_load    <= 1'b0;
         ks_seed    <= '0;
         gap_extend <= 1'b0;
         cmd_q      <= '0;
      end else begin
         ks_load    <= 1'b0;
         gap_extend <= 1'b0;
         if (!type_ok) begin
            st     <= S_IDLE;
            tx_req <= 1'b0;
            tx_ack <= 1'b0;
         end else begin
            unique case (st)
               S_IDLE: if (carrier) begin
                  ks_load <= 1'b1;
                  ks_seed <= '0;
                  st      <= S_IV;
               end
               S_IV: if (rx_err) begin
                  st <= S_IDLE;
               end else if (rx_valid) begin
                  if (rx_len == 5'(IV_BITS)) begin
                     ks_load <= 1'b1;
                     ks_seed <= rx_data[IV_BITS-1:0];
                     tx_req  <= 1'b1;
                     tx_len  <= 4'(CODE_BITS);
                     tx_data <= REPLY_BITS'(type_code);
                     tx_ack  <= 1'b0;
                     st      <= S_TYPE;
                  end else begin
                     st <= S_IDLE;
                  end
               end
               S_TYPE: if (tx_done) begin
                  tx_req <= 1'b0;
                  st     <= S_ACK;
               end
               S_ACK: if (rx_err) begin
                  st <= S_IDLE;
               end else if (rx_valid) begin
                  if (rx_len == 5'(CODE_BITS) && rx_data == 23'(ack_code)) begin
                     gap_extend <= 1'b1;
                     st         <= S_CMD;
                  end else begin
                     st <= S_IDLE;
                  end
               end
               S_CMD: if (rx_err) begin
                  st <= S_IDLE;
               end else if (rx_valid) begin
                  if (rx_len == len_rd) begin
                     cmd_q <= rx_data[CMD_MAX-1:0];
                     st    <= S_READ;
                  end else if (wr_fire) begin
                     tx_req  <= 1'b1;
                     tx_len  <= 4'd1;
                     tx_data <= 12'd1;
                     tx_ack  <= 1'b1;
                     st      <= S_REPLY;
                  end else begin
                     st <= S_IDLE;
                  end
               end
               S_READ: begin
                  tx_req  <= 1'b1;
                  tx_len  <= 4'(REPLY_BITS);
                  tx_data <= {rd_crc, mem_rdata};
                  tx_ack  <= 1'b0;
                  st      <= S_REPLY;
               end
               S_REPLY: if (tx_done) begin
                  tx_req <= 1'b0;
                  tx_ack <= 1'b0;
                  st     <= S_CMD;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/tag_session_chk.sv
module tag_session_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [1:0]  card_type,
   input logic        tx_req,
   input logic        tx_done,
   input logic [3:0]  tx_len,
   input logic [11:0] tx_data,
   input logic        tx_ack,
   input logic        ks_load,
   input logic        gap_extend
);
   // R2: an invalid card size keeps the controller silent
   p_badtype_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (card_type == 2'd3) |=> (!ks_load && !tx_req));

   // R4: the acknowledge pulse lasts one cycle
   p_gap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gap_extend |=> !gap_extend);

   // R5: a data reply is either the 6-bit code or the 12-bit read frame
   p_reply_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_ack) |-> (tx_len == 4'd6 || tx_len == 4'd12));

   // R6: the write acknowledge is a single one bit
   p_ack_form_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_ack) |-> (tx_len == 4'd1 && tx_data == 12'd1));

   // R10: a pending reply is held unchanged until the transmitter is done
   p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_done && card_type != 2'd3)
      |=> (tx_req && $stable(tx_len) && $stable(tx_data) && $stable(tx_ack)));

   // R10: the request drops after completion
   p_tx_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_done) |=> !tx_req);
endmodule

bind tag_session_ctrl tag_session_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .card_type  (card_type),
   .tx_req     (tx_req),
   .tx_done    (tx_done),
   .tx_len     (tx_len),
   .tx_data    (tx_data),
   .tx_ack     (tx_ack),
   .ks_load    (ks_load),
   .gap_extend (gap_extend)
);

// File: tb/tag_session_ctrl_test.sv
`timescale 1ns/1ps
module tag_session_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  card_type = 2'd0;
   logic        carrier = 1'b0;
   logic        rx_valid = 1'b0;
   logic        rx_err = 1'b0;
   logic [4:0]  rx_len = '0;
   logic [22:0] rx_data = '0;
   logic        tx_req;
   logic [3:0]  tx_len;
   logic [11:0] tx_data;
   logic        tx_ack;
   logic        tx_done = 1'b0;
   logic        ks_load;
   logic [6:0]  ks_seed;
   logic        gap_extend;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;
   logic [7:0] model [1024];

   always #2 clk = ~clk;

   tag_session_ctrl uut (
      .clk(clk), .rst_n(rst_n), .card_type(card_type), .carrier(carrier),
      .rx_valid(rx_valid), .rx_err(rx_err), .rx_len(rx_len), .rx_data(rx_data),
      .tx_req(tx_req), .tx_len(tx_len), .tx_data(tx_data), .tx_ack(tx_ack),
      .tx_done(tx_done), .ks_load(ks_load), .ks_seed(ks_seed),
      .gap_extend(gap_extend)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int cwid(input int t);
      return (t == 0) ? 6 : (t == 1) ? 9 : 11;
   endfunction

   function automatic int amask(input int t);
      return (t == 0) ? 'h1F : (t == 1) ? 'hFF : 'h3FF;
   endfunction

   // R8 reference: lsb first, init 5, reflected poly 0xC
   function automatic logic [3:0] ref_crc(input logic [18:0] d, input int n);
      logic [3:0] s = 4'h5;
      for (int i = 0; i < n; i++) begin
         logic fb = s[0] ^ d[i];
         s = s >> 1;
         if (fb) s = s ^ 4'hC;
      end
      return s;
   endfunction

   task automatic send(input int len, input logic [22:0] d);
      @(negedge clk);
      rx_valid = 1'b1; rx_len = 5'(len); rx_data = d;
      @(negedge clk);
      rx_valid = 1'b0; rx_len = '0; rx_data = '0;
   endtask

   task automatic send_err();
      @(negedge clk);
      rx_err = 1'b1;
      @(negedge clk);
      rx_err = 1'b0;
   endtask

   task automatic finish_tx(input string req);
      @(negedge clk);
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
      chk(tx_req == 1'b0, req, 32'(tx_req), 0);
   endtask

   task automatic pulse_carrier();
      @(negedge clk);
      carrier = 1'b1;
      @(negedge clk);
      carrier = 1'b0;
   endtask

   task automatic open_session(input int t, input logic [6:0] iv);
      logic [5:0] code = (t == 0) ? 6'h0D : (t == 1) ? 6'h1D : 6'h3D;
      logic [5:0] ackv = (t == 0) ? 6'h19 : 6'h39;
      card_type = 2'(t);
      pulse_carrier();
      chk(ks_load && ks_seed == 7'd0, "R2 seed clear", {24'd0, ks_load, ks_seed}, 32'h80);
      send(7, 23'(iv));
      chk(ks_load && ks_seed == iv, "R3 seed iv", {24'd0, ks_load, ks_seed}, {24'd0, 1'b1, iv});
      chk(tx_req && !tx_ack && tx_len == 4'd6 && tx_data == 12'(code), "R3 type code",
          {15'd0, tx_req, tx_len, tx_data}, {15'd0, 1'b1, 4'd6, 12'(code)});
      finish_tx("R10 drop after type code");
      send(6, 23'(ackv));
      chk(gap_extend == 1'b1, "R4 gap pulse", 32'(gap_extend), 1);
   endtask

   task automatic do_write(input int t, input int a, input logic [7:0] b, input bit good);
      int cw = cwid(t);
      logic [3:0] c = ref_crc((19'(b) << cw) | 19'(a << 1), cw + 8);
      logic [22:0] f;
      if (!good) c = c ^ 4'h3;
      f = (23'(c) << (cw + 8)) | (23'(b) << cw) | 23'(a << 1);
      send(cw + 12, f);
      if (good) begin
         chk(tx_req && tx_ack && tx_len == 4'd1 && tx_data == 12'd1, "R6 write ack",
             {15'd0, tx_req, tx_len, tx_data}, {15'd0, 1'b1, 4'd1, 12'd1});
         finish_tx("R10 drop after write ack");
         model[a] = b;
      end else begin
         chk(tx_req == 1'b0, "R7 no ack on bad checksum", 32'(tx_req), 0);
      end
   endtask

   task automatic do_read(input int t, input int a);
      int cw = cwid(t);
      logic [3:0] c = ref_crc((19'(model[a]) << cw) | 19'((a << 1) | 1), cw + 8);
      send(cw, 23'((a << 1) | 1));
      chk(tx_req == 1'b0, "R5 reply not before second edge", 32'(tx_req), 0);
      @(negedge clk);
      chk(tx_req && !tx_ack && tx_len == 4'd12 && tx_data == {c, model[a]},
          "R5 R8 read reply", {15'd0, tx_req, tx_len, tx_data},
          {15'd0, 1'b1, 4'd12, c, model[a]});
      finish_tx("R10 drop after read reply");
   endtask

   // read frame that must get no answer because the session has ended
   task automatic probe_dead(input int t, input string req);
      send(cwid(t), 23'd1);
      @(negedge clk);
      chk(tx_req == 1'b0, req, 32'(tx_req), 0);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!tx_req && !tx_ack && !ks_load && !gap_extend, "R1 reset outputs",
          {28'd0, tx_req, tx_ack, ks_load, gap_extend}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tx_req && !ks_load && !gap_extend, "R1 after release",
          {29'd0, tx_req, ks_load, gap_extend}, 0);

      // invalid card size: no session ever starts
      card_type = 2'd3;
      pulse_carrier();
      chk(ks_load == 1'b0, "R2 type 3 stays idle", 32'(ks_load), 0);
      send(7, 23'h2A);
      chk(tx_req == 1'b0 && ks_load == 1'b0, "R2 type 3 no reply",
          {30'd0, tx_req, ks_load}, 0);

      // sweeps per card size
      for (int t = 0; t < 3; t++) begin
         int step = (t == 2) ? 13 : 1;
         int top  = (t == 0) ? 22 : amask(t) + 1;
         open_session(t, 7'(7'h25 + t * 17));
         for (int a = 0; a < top; a += step)
            do_write(t, a, 8'((a * 37 + t * 11 + 5) & 'hFF), 1'b1);
         for (int a = 0; a < top; a += step)
            do_read(t, a);
         do_write(t, amask(t), 8'h5A, 1'b1);
         do_read(t, amask(t));

         // checksum mismatch: no store, session over
         do_write(t, step, 8'hC3, 1'b0);
         probe_dead(t, "R7 session ended after bad checksum");
         open_session(t, 7'h11);
         do_read(t, step);

         // unexpected length ends the session
         send(cwid(t) + 1, 23'h3);
         chk(tx_req == 1'b0, "R9 odd length no reply", 32'(tx_req), 0);
         probe_dead(t, "R9 session ended after odd length");

         // receive error ends the session
         open_session(t, 7'h7F);
         send_err();
         probe_dead(t, "R9 session ended after rx_err");
      end

      // IV of wrong length
      card_type = 2'd1;
      pulse_carrier();
      send(8, 23'h55);
      chk(tx_req == 1'b0, "R3 wrong IV length", 32'(tx_req), 0);
      send(7, 23'h55);
      chk(tx_req == 1'b0 && ks_load == 1'b0, "R3 back in idle",
          {30'd0, tx_req, ks_load}, 0);

      // wrong acknowledge values
      for (int t = 0; t < 3; t++) begin
         card_type = 2'(t);
         pulse_carrier();
         send(7, 23'h33);
         finish_tx("R10 drop after type code");
         send(6, (t == 0) ? 23'h39 : 23'h19);
         chk(gap_extend == 1'b0, "R4 wrong ack value", 32'(gap_extend), 0);
         probe_dead(t, "R4 no session after wrong ack");
      end

      // acknowledge of right value but wrong length
      card_type = 2'd2;
      pulse_carrier();
      send(7, 23'h01);
      finish_tx("R10 drop after type code");
      send(7, 23'h39);
      chk(gap_extend == 1'b0, "R4 ack length", 32'(gap_extend), 0);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule